// File: doc/BRIEF.md
# Field Inversion Exponent Sequencer

This block steers a modular-arithmetic datapath through a complete field inversion over the prime 2^255−19. It computes x^(p−2), which is the inverse of x. The work is a fixed addition chain of squarings and multiplications, and the block emits that chain one micro-operation at a time. A pulse on `start` launches the chain. Each micro-operation stays on the output bus until the datapath acknowledges it. The cycle after the final acknowledge, `done` pulses.

The datapath keeps two operand banks, and each bank holds fourteen slots. A multiply fetches both of its operands from one bank and stores its product in the other bank. A long run of squarings therefore bounces between two scratch slots, one in each bank. Before a run starts, a copy operation places the stage's result in a scratch slot of the opposite bank, and often a second copy stores it in a named slot so that a later multiply can use it. The powers the chain builds are x^2, x^9, x^11, x^(2^5−1), x^(2^10−1), x^(2^20−1), x^(2^40−1), x^(2^50−1), x^(2^100−1), x^(2^200−1) and x^(2^250−1). Five more squarings and a multiply by x^11 complete the exponent.

The datapath, the arithmetic units and the operand storage belong to the surrounding design.

Top module: `inv_chain_seq`

## Requirements
- R1: Reset is asynchronous and active low. While `rst_n` is low, and on the first cycle after it is released, `uop_valid` and `done` are 0. A reset during a chain abandons that chain at once.
- R2: A `start` sampled high while `uop_valid` is 0 raises `uop_valid` on the next cycle and presents operation 0. Operation 0 is a copy (code 0) from bank 0 slot 4 to bank 1 slot 4.
- R3: While `uop_valid` is 1 and `uop_ack` is 0, every micro-operation output holds its value into the next cycle.
- R4: An acknowledge of operation k, where k is not the last, presents operation k+1 on the next cycle with `uop_valid` still 1. An acknowledge while `uop_valid` is 0 has no effect.
- R5: Each chain has exactly 278 operations. Each operation carries a code, a source bank, two source slots, a destination bank and a destination slot. The codes are 0 for copy and 3 for multiply. The banks are 0 for low and 1 for high. The slots are 0 zero, 1 one, 2 scratch A, 3 scratch B, 4 x, 5 x^2, 6 x^9, 7 x^11, 8 x^(2^5−1), 9 x^(2^10−1), 10 x^(2^20−1), 11 x^(2^40−1), 12 x^(2^50−1) and 13 x^(2^100−1). A copy repeats its source slot in the second source field. The squaring runs have lengths 5, 10, 20, 10, 50, 100, 50 and 5. The run of 10 that follows the 2^40−1 stage multiplies by the slot 9 value.
- R6: Every multiply has a destination bank that differs from its source bank, so consecutive squarings alternate between the banks.
- R7: `uop_mod` is 1, which selects reduction by 2p, on every operation presented.
- R8: `done` is high for exactly one cycle: the cycle after the final operation is acknowledged. `uop_valid` falls in that same cycle.
- R9: A `start` while `uop_valid` is 1 is ignored, and the presented operation does not change.
- R10: A datapath stub follows each operation. Copies transfer exponents, and multiplies add the exponents of their operands. With x in bank 0 slot 4, the stub ends with the exponent 2^255−21 in bank 1 slot 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a chain (accepted only while idle) |
| uop_ack | input | 1 | Datapath accepts the presented operation |
| uop_valid | output | 1 | An operation is presented; also the busy indication |
| uop_code | output | 2 | Operation code: 0 copy, 3 multiply |
| uop_src_bank | output | 1 | Bank both sources are read from |
| uop_src_a | output | 4 | First source slot |
| uop_src_b | output | 4 | Second source slot |
| uop_dst_bank | output | 1 | Bank the result is written to |
| uop_dst | output | 4 | Destination slot |
| uop_mod | output | 1 | Reduction select: 1 = modulus 2p |
| done | output | 1 | One-cycle pulse after the final operation is accepted |

## Verification
The assertions take two things for granted. The datapath raises `uop_ack` only while an operation is presented, and `start` behaves as a pulse; a start that arrives while the sequencer is busy must simply be ignored. The stimulus drives `uop_ack` for one cycle, and only after it has observed `uop_valid` high. It waits zero, one or two cycles before each acknowledge. It applies one stray acknowledge while the sequencer is idle and one start pulse in the middle of a chain. These cases cover every hold-and-advance path without driving the handshake outside its contract.

// File: rtl/inv_chain_pkg.sv
package inv_chain_pkg;

  localparam int SLOT_W = 4;

  // squaring run lengths in chain order
  localparam int RUN0 = 5;
  localparam int RUN1 = 10;
  localparam int RUN2 = 20;
  localparam int RUN3 = 10;
  localparam int RUN4 = 50;
  localparam int RUN5 = 100;
  localparam int RUN6 = 50;
  localparam int RUN7 = 5;

  // run start (S) and run end (E) positions derived from the lengths
  localparam int S0 = 10;
  localparam int E0 = S0 + RUN0;
  localparam int S1 = E0 + 3;
  localparam int E1 = S1 + RUN1;
  localparam int S2 = E1 + 3;
  localparam int E2 = S2 + RUN2;
  localparam int S3 = E2 + 2;
  localparam int E3 = S3 + RUN3;
  localparam int S4 = E3 + 3;
  localparam int E4 = S4 + RUN4;
  localparam int S5 = E4 + 3;
  localparam int E5 = S5 + RUN5;
  localparam int S6 = E5 + 1;
  localparam int E6 = S6 + RUN6;
  localparam int S7 = E6 + 1;
  localparam int E7 = S7 + RUN7;
  localparam int NUM_OPS = E7 + 2;
  localparam int STEP_W  = $clog2(NUM_OPS);

  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [1:0] {
    OPC_MOVE = 2'd0,
    OPC_ADD  = 2'd1,
    OPC_SUB  = 2'd2,
    OPC_MUL  = 2'd3
  } opc_e;

  localparam logic BNK0 = 1'b0;
  localparam logic BNK1 = 1'b1;

  localparam slot_t SL_ZERO  = 4'd0;
  localparam slot_t SL_ONE   = 4'd1;
  localparam slot_t SL_SCR_A = 4'd2;
  localparam slot_t SL_SCR_B = 4'd3;
  localparam slot_t SL_P1    = 4'd4;
  localparam slot_t SL_P2    = 4'd5;
  localparam slot_t SL_P9    = 4'd6;
  localparam slot_t SL_P11   = 4'd7;
  localparam slot_t SL_M5    = 4'd8;
  localparam slot_t SL_M10   = 4'd9;
  localparam slot_t SL_M20   = 4'd10;
  localparam slot_t SL_M40   = 4'd11;
  localparam slot_t SL_M50   = 4'd12;
  localparam slot_t SL_M100  = 4'd13;

  typedef struct packed {
    opc_e  code;
    logic  src_bank;
    slot_t src_a;
    slot_t src_b;
    logic  dst_bank;
    slot_t dst;
    logic  mod2p;
  } uop_t;

endpackage

// File: rtl/inv_chain_rom.sv
module inv_chain_rom
  import inv_chain_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  output uop_t              op_o
);

  function automatic uop_t mk(input opc_e c, input logic sb, input slot_t a,
                              input slot_t b, input logic db, input slot_t d);
    uop_t u;
    u.code     = c;
    u.src_bank = sb;
    u.src_a    = a;
    u.src_b    = b;
    u.dst_bank = db;
    u.dst      = d;
    u.mod2p    = 1'b1;
    return u;
  endfunction

  function automatic uop_t cp(input logic sb, input slot_t a, input slot_t d);
    return mk(OPC_MOVE, sb, a, a, ~sb, d);
  endfunction

  // one squaring of a ping-pong run; odd positions run in the reverse direction
  function automatic uop_t sq(input logic first_bank, input slot_t first_slot,
                              input slot_t other_slot, input logic odd);
    logic sb;
    sb = first_bank ^ odd;
    return mk(OPC_MUL, sb, odd ? other_slot : first_slot, odd ? other_slot : first_slot,
              ~sb, odd ? first_slot : other_slot);
  endfunction

  logic [31:0] st;

  always_comb begin
    st   = 32'(step_i);
    op_o = mk(OPC_MOVE, BNK0, SL_ZERO, SL_ZERO, BNK1, SL_ZERO);
    if (st < S0) begin
      case (st)
        0:       op_o = cp(BNK0, SL_P1, SL_P1);
        1:       op_o = mk(OPC_MUL, BNK0, SL_P1, SL_P1, BNK1, SL_P2);
        2:       op_o = mk(OPC_MUL, BNK1, SL_P2, SL_P2, BNK0, SL_SCR_A);
        3:       op_o = mk(OPC_MUL, BNK0, SL_SCR_A, SL_SCR_A, BNK1, SL_SCR_B);
        4:       op_o = mk(OPC_MUL, BNK1, SL_SCR_B, SL_P1, BNK0, SL_P9);
        5:       op_o = cp(BNK1, SL_P2, SL_P2);
        6:       op_o = mk(OPC_MUL, BNK0, SL_P9, SL_P2, BNK1, SL_P11);
        7:       op_o = mk(OPC_MUL, BNK1, SL_P11, SL_P11, BNK0, SL_SCR_A);
        8:       op_o = mk(OPC_MUL, BNK0, SL_SCR_A, SL_P9, BNK1, SL_M5);
        default: op_o = cp(BNK1, SL_M5, SL_SCR_A);
      endcase
    end
    else if (st < E0)     op_o = sq(BNK0, SL_SCR_A, SL_SCR_B, st[0] ^ S0[0]);
    else if (st == E0)    op_o = mk(OPC_MUL, BNK1, SL_SCR_B, SL_M5, BNK0, SL_M10);
    else if (st == E0+1)  op_o = cp(BNK0, SL_M10, SL_SCR_A);
    else if (st == E0+2)  op_o = cp(BNK0, SL_M10, SL_M10);
    else if (st < E1)     op_o = sq(BNK1, SL_SCR_A, SL_SCR_B, st[0] ^ S1[0]);
    else if (st == E1)    op_o = mk(OPC_MUL, BNK1, SL_SCR_A, SL_M10, BNK0, SL_M20);
    else if (st == E1+1)  op_o = cp(BNK0, SL_M20, SL_SCR_A);
    else if (st == E1+2)  op_o = cp(BNK0, SL_M20, SL_M20);
    else if (st < E2)     op_o = sq(BNK1, SL_SCR_A, SL_SCR_B, st[0] ^ S2[0]);
    else if (st == E2)    op_o = mk(OPC_MUL, BNK1, SL_SCR_A, SL_M20, BNK0, SL_M40);
    else if (st == E2+1)  op_o = cp(BNK0, SL_M40, SL_SCR_A);
    else if (st < E3)     op_o = sq(BNK1, SL_SCR_A, SL_SCR_B, st[0] ^ S3[0]);
    else if (st == E3)    op_o = mk(OPC_MUL, BNK1, SL_SCR_A, SL_M10, BNK0, SL_M50);
    else if (st == E3+1)  op_o = cp(BNK0, SL_M50, SL_SCR_A);
    else if (st == E3+2)  op_o = cp(BNK0, SL_M50, SL_M50);
    else if (st < E4)     op_o = sq(BNK1, SL_SCR_A, SL_SCR_B, st[0] ^ S4[0]);
    else if (st == E4)    op_o = mk(OPC_MUL, BNK1, SL_SCR_A, SL_M50, BNK0, SL_M100);
    else if (st == E4+1)  op_o = cp(BNK0, SL_M100, SL_SCR_A);
    else if (st == E4+2)  op_o = cp(BNK0, SL_M100, SL_M100);
    else if (st < E5)     op_o = sq(BNK1, SL_SCR_A, SL_SCR_B, st[0] ^ S5[0]);
    else if (st == E5)    op_o = mk(OPC_MUL, BNK1, SL_SCR_A, SL_M100, BNK0, SL_SCR_B);
    else if (st < E6)     op_o = sq(BNK0, SL_SCR_B, SL_SCR_A, st[0] ^ S6[0]);
    else if (st == E6)    op_o = mk(OPC_MUL, BNK0, SL_SCR_B, SL_M50, BNK1, SL_SCR_A);
    else if (st < E7)     op_o = sq(BNK1, SL_SCR_A, SL_SCR_B, st[0] ^ S7[0]);
    else if (st == E7)    op_o = cp(BNK1, SL_P11, SL_P11);
    else                  op_o = mk(OPC_MUL, BNK0, SL_SCR_B, SL_P11, BNK1, SL_SCR_A);
  end

endmodule

// File: rtl/inv_step_ctrl.sv
module inv_step_ctrl #(
  parameter int NUM_STEPS = 278,
  localparam int STEP_W   = $clog2(NUM_STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ack_i,
  output logic              valid_o,
  output logic              done_o,
  output logic [STEP_W-1:0] step_o
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

  logic              valid_q, valid_d;
  logic              done_q, done_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  logic              is_last;

  assign is_last = (step_q == LAST);

  always_comb begin
    valid_d = valid_q;
    done_d  = 1'b0;
    step_d  = step_q;
    step_en = 1'b0;
    if (!valid_q) begin
      if (start_i) begin
        valid_d = 1'b1;
        step_d  = '0;
        step_en = 1'b1;
      end
    end
    else if (ack_i) begin
      if (is_last) begin
        valid_d = 1'b0;
        done_d  = 1'b1;
      end
      else begin
        step_d  = step_q + STEP_W'(1);
        step_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
    end
    else begin
      valid_q <= valid_d;
      done_q  <= done_d;
      if (step_en) step_q <= step_d;
    end
  end

  assign valid_o = valid_q;
  assign done_o  = done_q;
  assign step_o  = step_q;

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && start_i) |=> (valid_o && step_o == '0));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ack_i) |=> (valid_o && $stable(step_o)));

  // R4
  ack_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ack_i && step_o != LAST) |=> (valid_o && step_o == $past(step_o) + STEP_W'(1)));

  // R4
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i) |=> (!valid_o && !done_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(valid_o && ack_i && step_o == LAST) && !valid_o));

  // R5
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o <= LAST);

endmodule

// File: rtl/inv_chain_seq.sv
module inv_chain_seq
  import inv_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              uop_ack,
  output logic              uop_valid,
  output logic [1:0]        uop_code,
  output logic              uop_src_bank,
  output logic [SLOT_W-1:0] uop_src_a,
  output logic [SLOT_W-1:0] uop_src_b,
  output logic              uop_dst_bank,
  output logic [SLOT_W-1:0] uop_dst,
  output logic              uop_mod,
  output logic              done
);

  logic [STEP_W-1:0] step;
  uop_t              op;

  inv_step_ctrl #(
    .NUM_STEPS (NUM_OPS)
  ) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .ack_i   (uop_ack),
    .valid_o (uop_valid),
    .done_o  (done),
    .step_o  (step)
  );

  inv_chain_rom i_rom (
    .step_i (step),
    .op_o   (op)
  );

  assign uop_code     = op.code;
  assign uop_src_bank = op.src_bank;
  assign uop_src_a    = op.src_a;
  assign uop_src_b    = op.src_b;
  assign uop_dst_bank = op.dst_bank;
  assign uop_dst      = op.dst;
  assign uop_mod      = op.mod2p;

  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ack) |=> $stable({uop_code, uop_src_bank, uop_src_a, uop_src_b,
                                         uop_dst_bank, uop_dst, uop_mod}));

  // R6
  bank_pingpong_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_code == OPC_MUL) |-> (uop_src_bank != uop_dst_bank));

  // R7
  mod_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid |-> uop_mod);

  // R2
  first_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uop_valid && start) |=> (uop_code == OPC_MOVE && uop_src_bank == BNK0 &&
                               uop_src_a == SL_P1 && uop_dst_bank == BNK1 && uop_dst == SL_P1));

  // R5
  move_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && uop_code == OPC_MOVE) |-> (uop_src_a == uop_src_b && uop_src_bank != uop_dst_bank));

endmodule

// File: tb/test_inv_chain_seq.sv
module test_inv_chain_seq;

  localparam int NOPS = 278;
  localparam int NSEG = 36;
  localparam int WDOG = 60000;
  localparam logic [255:0] TARGET = (256'd1 << 255) - 256'd21;

  localparam logic [1:0] MV = 2'd0;
  localparam logic [1:0] ML = 2'd3;
  localparam logic B0 = 1'b0;
  localparam logic B1 = 1'b1;
  localparam logic [3:0] SA = 4'd2, SB = 4'd3, P1 = 4'd4, P2 = 4'd5, P9 = 4'd6, P11 = 4'd7;
  localparam logic [3:0] M5 = 4'd8, M10 = 4'd9, M20 = 4'd10, M40 = 4'd11, M50 = 4'd12, M100 = 4'd13;
  localparam logic [3:0] NA = 4'd0;

  // {run, code, src bank, src a, src b, dst bank, dst, run length}
  // run entries: src bank / src a are the first squaring's source, src b the partner slot
  localparam logic [24:0] SEG [0:NSEG-1] = '{
    {1'b0, MV, B0, P1,   P1,   B1, P1,   8'd1},
    {1'b0, ML, B0, P1,   P1,   B1, P2,   8'd1},
    {1'b0, ML, B1, P2,   P2,   B0, SA,   8'd1},
    {1'b0, ML, B0, SA,   SA,   B1, SB,   8'd1},
    {1'b0, ML, B1, SB,   P1,   B0, P9,   8'd1},
    {1'b0, MV, B1, P2,   P2,   B0, P2,   8'd1},
    {1'b0, ML, B0, P9,   P2,   B1, P11,  8'd1},
    {1'b0, ML, B1, P11,  P11,  B0, SA,   8'd1},
    {1'b0, ML, B0, SA,   P9,   B1, M5,   8'd1},
    {1'b0, MV, B1, M5,   M5,   B0, SA,   8'd1},
    {1'b1, ML, B0, SA,   SB,   B1, NA,   8'd5},
    {1'b0, ML, B1, SB,   M5,   B0, M10,  8'd1},
    {1'b0, MV, B0, M10,  M10,  B1, SA,   8'd1},
    {1'b0, MV, B0, M10,  M10,  B1, M10,  8'd1},
    {1'b1, ML, B1, SA,   SB,   B0, NA,   8'd10},
    {1'b0, ML, B1, SA,   M10,  B0, M20,  8'd1},
    {1'b0, MV, B0, M20,  M20,  B1, SA,   8'd1},
    {1'b0, MV, B0, M20,  M20,  B1, M20,  8'd1},
    {1'b1, ML, B1, SA,   SB,   B0, NA,   8'd20},
    {1'b0, ML, B1, SA,   M20,  B0, M40,  8'd1},
    {1'b0, MV, B0, M40,  M40,  B1, SA,   8'd1},
    {1'b1, ML, B1, SA,   SB,   B0, NA,   8'd10},
    {1'b0, ML, B1, SA,   M10,  B0, M50,  8'd1},
    {1'b0, MV, B0, M50,  M50,  B1, SA,   8'd1},
    {1'b0, MV, B0, M50,  M50,  B1, M50,  8'd1},
    {1'b1, ML, B1, SA,   SB,   B0, NA,   8'd50},
    {1'b0, ML, B1, SA,   M50,  B0, M100, 8'd1},
    {1'b0, MV, B0, M100, M100, B1, SA,   8'd1},
    {1'b0, MV, B0, M100, M100, B1, M100, 8'd1},
    {1'b1, ML, B1, SA,   SB,   B0, NA,   8'd100},
    {1'b0, ML, B1, SA,   M100, B0, SB,   8'd1},
    {1'b1, ML, B0, SB,   SA,   B1, NA,   8'd50},
    {1'b0, ML, B0, SB,   M50,  B1, SA,   8'd1},
    {1'b1, ML, B1, SA,   SB,   B0, NA,   8'd5},
    {1'b0, MV, B1, P11,  P11,  B0, P11,  8'd1},
    {1'b0, ML, B0, SB,   P11,  B1, SA,   8'd1}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic       uop_ack;
  logic       uop_valid;
  logic [1:0] uop_code;
  logic       uop_src_bank;
  logic [3:0] uop_src_a;
  logic [3:0] uop_src_b;
  logic       uop_dst_bank;
  logic [3:0] uop_dst;
  logic       uop_mod;
  logic       done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [15:0]  exp_op [0:NOPS-1];
  logic [255:0] eb [0:1][0:15];

  always #4 clk = ~clk;

  inv_chain_seq i_inv_chain_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .uop_ack      (uop_ack),
    .uop_valid    (uop_valid),
    .uop_code     (uop_code),
    .uop_src_bank (uop_src_bank),
    .uop_src_a    (uop_src_a),
    .uop_src_b    (uop_src_b),
    .uop_dst_bank (uop_dst_bank),
    .uop_dst      (uop_dst),
    .uop_mod      (uop_mod),
    .done         (done)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] obs();
    return {uop_code, uop_src_bank, uop_src_a, uop_src_b, uop_dst_bank, uop_dst};
  endfunction

  task automatic run_chain(input int mode, input bit poke);
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 16; s++) eb[b][s] = '0;
    eb[0][4] = 256'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 valid after start", 256'(uop_valid), 256'd1);
    chk("R2 first op", 256'(obs()), 256'(exp_op[0]));
    for (int i = 0; i < NOPS; i++) begin
      int waits;
      waits = (i * 5 + mode) % 3;
      if (poke && i == 5) waits = 2;
      chk("R5 op fields", 256'(obs()), 256'(exp_op[i]));
      chk("R7 modulus select", 256'(uop_mod), 256'd1);
      if (uop_code == 2'd3) chk("R6 bank swap", 256'(uop_src_bank != uop_dst_bank), 256'd1);
      for (int w = 0; w < waits; w++) begin
        if (poke && i == 5 && w == 0) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke && i == 5) chk("R9 start while busy", 256'({uop_valid, obs()}), 256'({1'b1, exp_op[i]}));
        else                chk("R3 hold until ack", 256'({uop_valid, obs()}), 256'({1'b1, exp_op[i]}));
      end
      if (uop_code == 2'd3) eb[uop_dst_bank][uop_dst] = eb[uop_src_bank][uop_src_a] + eb[uop_src_bank][uop_src_b];
      else                  eb[uop_dst_bank][uop_dst] = eb[uop_src_bank][uop_src_a];
      uop_ack = 1'b1;
      @(negedge clk);
      uop_ack = 1'b0;
      if (i < NOPS - 1) begin
        chk("R4 next op presented", 256'({uop_valid, done}), 256'(2'b10));
      end
      else begin
        chk("R8 valid falls", 256'(uop_valid), 256'd0);
        chk("R8 done pulse", 256'(done), 256'd1);
        @(negedge clk);
        chk("R8 done one cycle", 256'(done), 256'd0);
      end
    end
    chk("R10 final exponent", eb[1][2], TARGET);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n   = 1'b0;
    start   = 1'b0;
    uop_ack = 1'b0;

    n = 0;
    for (int s = 0; s < NSEG; s++) begin
      logic [24:0] e;
      e = SEG[s];
      if (!e[24]) begin
        exp_op[n] = e[23:8];
        n++;
      end
      else begin
        for (int r = 0; r < int'(e[7:0]); r++) begin
          logic odd, sbk;
          logic [3:0] a, d;
          odd = r[0];
          sbk = e[21] ^ odd;
          a   = odd ? e[16:13] : e[20:17];
          d   = odd ? e[20:17] : e[16:13];
          exp_op[n] = {2'd3, sbk, a, a, ~sbk, d};
          n++;
        end
      end
    end
    chk("R5 chain length", 256'(n), 256'(NOPS));

    repeat (3) @(negedge clk);
    chk("R1 outputs during reset", 256'({uop_valid, done}), 256'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", 256'({uop_valid, done}), 256'd0);

    uop_ack = 1'b1;
    @(negedge clk);
    uop_ack = 1'b0;
    @(negedge clk);
    chk("R4 ack while idle", 256'({uop_valid, done}), 256'd0);

    run_chain(0, 1'b0);
    run_chain(1, 1'b1);

    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      uop_ack = 1'b1;
      @(negedge clk);
      uop_ack = 1'b0;
    end
    chk("R4 mid chain op", 256'(obs()), 256'(exp_op[3]));
    rst_n = 1'b0;
    #1;
    chk("R1 async abort", 256'({uop_valid, done}), 256'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after abort", 256'(uop_valid), 256'd0);

    run_chain(2, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule